// File: doc/BRIEF.md
# Folded Three-Operand Adder

This block forms the sum of three unsigned operands with one physical two-input adder that is reused for both additions of each sample set. A one-bit phase register alternates between an operand phase and a completion phase on every clock. In the operand phase the adder adds `opnd_a` and `opnd_b`, and the partial result is captured in a feedback register. In the completion phase the adder adds that stored partial sum to `opnd_c`. The finished sum is registered and shown on the output during the following operand phase, while the next `opnd_a` and `opnd_b` are already being added.

The host watches `phase_o`. It presents `opnd_a`, `opnd_b` and `set_valid` while `phase_o` is 0, and it presents `opnd_c` while `phase_o` is 1. Throughput is one sum every two clocks. The result is two bits wider than an operand, so the sum is always exact.

Top module: `tri_add_fold`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it is released, `phase_o` is 0 and `sum_valid_o` is 0.
- R2: After reset, `phase_o` toggles on every clock edge: 0 is the operand phase and 1 is the completion phase.
- R3: `sum_o` is W+2 bits wide and equals the exact unsigned sum a+b+c for every combination of W-bit operands.
- R4: The sum of a set whose a and b are applied in phase-0 cycle k and whose c is applied in cycle k+1 appears on `sum_o` in cycle k+2, the phase-0 cycle in which the next a and b are applied.
- R5: `sum_valid_o` is high for exactly one cycle per accepted set. That cycle is a phase-0 cycle, and `sum_valid_o` is never high while `phase_o` is 1.
- R6: A set whose `set_valid` is low during its phase-0 cycle produces no `sum_valid_o` pulse.
- R7: `opnd_c` has no effect during phase 0. `opnd_a`, `opnd_b` and `set_valid` have no effect during phase 1.
- R8: Sets applied back to back, one every two cycles, each give a correct result two cycles apart, with no gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_valid | input | 1 | Marks a new operand set; sampled in phase 0 |
| opnd_a | input | W | First operand; sampled in phase 0 |
| opnd_b | input | W | Second operand; sampled in phase 0 |
| opnd_c | input | W | Third operand; sampled in phase 1 |
| phase_o | output | 1 | Current schedule phase (0 = operand phase, 1 = completion phase) |
| sum_o | output | W+2 | Registered three-operand sum |
| sum_valid_o | output | 1 | High in the phase-0 cycle that presents a finished sum |

## Verification
With a 3-bit operand width, every one of the 512 combinations of a, b and c is driven back to back. This shows whether the partial sum and the third operand are combined without a width or carry error, and whether each result lands in the right cycle. In each phase the operands that phase should ignore are driven with complemented values, so a steering mux that picks its input in the wrong phase gives a wrong sum. A run of sets with `set_valid` alternating between high and low shows whether the valid pulse follows only accepted sets and never reaches a phase-1 cycle.

// File: rtl/tri_add_fold_pkg.sv
package tri_add_fold_pkg;

  typedef enum logic {
    PH_OPND = 1'b0,
    PH_DONE = 1'b1
  } phase_e;

  function automatic int unsigned sum_width(input int unsigned opnd_w);
    return opnd_w + 2;
  endfunction

endpackage

// File: rtl/tri_add_fold_phase.sv
module tri_add_fold_phase
  import tri_add_fold_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  output phase_e phase
);

  phase_e phase_q;
  phase_e phase_d;

  always_comb begin
    phase_d = (phase_q == PH_OPND) ? PH_DONE : PH_OPND;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_OPND;
    else        phase_q <= phase_d;
  end

  assign phase = phase_q;

  // R2: the schedule alternates on every edge out of reset
  a_r2_phase_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (phase_q != $past(phase_q)));

endmodule

// File: rtl/tri_add_fold_steer.sv
module tri_add_fold_steer
  import tri_add_fold_pkg::*;
#(
  parameter int unsigned W  = 8,
  localparam int unsigned SW = sum_width(W)
) (
  input  phase_e          phase,
  input  logic [W-1:0]    opnd_a,
  input  logic [W-1:0]    opnd_b,
  input  logic [W-1:0]    opnd_c,
  input  logic [SW-1:0]   partial,
  output logic [SW-1:0]   add_x,
  output logic [SW-1:0]   add_y
);

  localparam int unsigned PADW = SW - W;

  always_comb begin
    if (phase == PH_OPND) begin
      add_x = {{PADW{1'b0}}, opnd_a};
      add_y = {{PADW{1'b0}}, opnd_b};
    end else begin
      add_x = partial;
      add_y = {{PADW{1'b0}}, opnd_c};
    end
  end

endmodule

// File: rtl/tri_add_fold_adder.sv
module tri_add_fold_adder #(
  parameter int unsigned AW     = 10,
  parameter bit          RIPPLE = 1'b0
) (
  input  logic [AW-1:0] x,
  input  logic [AW-1:0] y,
  output logic [AW-1:0] s
);

  generate
    if (RIPPLE) begin : g_ripple
      logic [AW-1:0] cy;
      assign cy[0] = 1'b0;
      for (genvar i = 0; i < AW; i++) begin : g_bit
        assign s[i] = x[i] ^ y[i] ^ cy[i];
        if (i < AW - 1) begin : g_cy
          assign cy[i+1] = (x[i] & y[i]) | (cy[i] & (x[i] ^ y[i]));
        end
      end
    end else begin : g_behav
      assign s = x + y;
    end
  endgenerate

endmodule

// File: rtl/tri_add_fold.sv
module tri_add_fold
  import tri_add_fold_pkg::*;
#(
  parameter int unsigned W      = 8,
  parameter bit          RIPPLE = 1'b0,
  localparam int unsigned SW    = sum_width(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_valid,
  input  logic [W-1:0]  opnd_a,
  input  logic [W-1:0]  opnd_b,
  input  logic [W-1:0]  opnd_c,
  output logic          phase_o,
  output logic [SW-1:0] sum_o,
  output logic          sum_valid_o
);

  phase_e        phase;
  logic [SW-1:0] add_x;
  logic [SW-1:0] add_y;
  logic [SW-1:0] add_s;

  logic [SW-1:0] part_q;
  logic [SW-1:0] part_d;
  logic          part_en;
  logic          pend_q;
  logic          pend_d;
  logic [SW-1:0] res_q;
  logic [SW-1:0] res_d;
  logic          res_en;
  logic          oval_q;
  logic          oval_d;

  tri_add_fold_phase u_phase (
    .clk   (clk),
    .rst_n (rst_n),
    .phase (phase)
  );

  tri_add_fold_steer #(.W(W)) u_steer (
    .phase   (phase),
    .opnd_a  (opnd_a),
    .opnd_b  (opnd_b),
    .opnd_c  (opnd_c),
    .partial (part_q),
    .add_x   (add_x),
    .add_y   (add_y)
  );

  tri_add_fold_adder #(.AW(SW), .RIPPLE(RIPPLE)) u_add (
    .x (add_x),
    .y (add_y),
    .s (add_s)
  );

  // next-state
  always_comb begin
    part_en = (phase == PH_OPND);
    res_en  = (phase == PH_DONE);
    part_d  = add_s;
    res_d   = add_s;
    pend_d  = pend_q;
    oval_d  = 1'b0;
    if (phase == PH_OPND) begin
      pend_d = set_valid;
    end else begin
      oval_d = pend_q;
    end
  end

  // datapath registers: enabled per phase, no reset needed
  always_ff @(posedge clk) begin
    if (part_en) part_q <= part_d;
    if (res_en)  res_q  <= res_d;
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      oval_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      oval_q <= oval_d;
    end
  end

  assign phase_o     = phase;
  assign sum_o       = res_q;
  assign sum_valid_o = oval_q;

  // R5: a finished sum is shown only in the operand phase
  a_r5_valid_in_opnd: assert property (@(posedge clk) disable iff (!rst_n)
    sum_valid_o |-> (phase_o == 1'b0));

  // R5: one pulse per set
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    sum_valid_o |=> !sum_valid_o);

  // R3, R4: exact sum of operands sampled two and one cycles earlier
  a_r3_exact_sum: assert property (@(posedge clk) disable iff (!rst_n)
    sum_valid_o |-> (sum_o == (SW'($past(opnd_a, 2)) + SW'($past(opnd_b, 2))
                               + SW'($past(opnd_c, 1)))));

  // R6: a set not flagged valid produces no pulse
  a_r6_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (!phase_o && !set_valid) |=> ##1 !sum_valid_o);

  // R1: nothing is valid during reset
  always_comb begin
    if (!rst_n) a_r1_reset_quiet: assert (!sum_valid_o && !phase_o);
  end

endmodule

// File: tb/tri_add_fold_bench.sv
`timescale 1ns/1ps
module tri_add_fold_bench;

  localparam int unsigned W  = 3;
  localparam int unsigned SW = W + 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          set_valid = 1'b0;
  logic [W-1:0]  opnd_a = '0;
  logic [W-1:0]  opnd_b = '0;
  logic [W-1:0]  opnd_c = '0;
  logic          phase_o;
  logic [SW-1:0] sum_o;
  logic          sum_valid_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  tri_add_fold #(.W(W), .RIPPLE(1'b1)) u_tri_add_fold (
    .clk         (clk),
    .rst_n       (rst_n),
    .set_valid   (set_valid),
    .opnd_a      (opnd_a),
    .opnd_b      (opnd_b),
    .opnd_c      (opnd_c),
    .phase_o     (phase_o),
    .sum_o       (sum_o),
    .sum_valid_o (sum_valid_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  bit prev_v   = 0;
  int prev_exp = 0;

  // one set: phase-0 cycle then phase-1 cycle; garbage on off-phase inputs (R7)
  task automatic run_set(input int a, input int b, input int c, input bit v);
    chk("R2 phase0", phase_o, 0);
    chk("R5/R6/R8 valid", sum_valid_o, prev_v);
    if (prev_v) chk("R3/R4/R7/R8 sum", sum_o, prev_exp);
    opnd_a = W'(a); opnd_b = W'(b); set_valid = v;
    opnd_c = ~W'(c);
    @(negedge clk);
    chk("R2 phase1", phase_o, 1);
    chk("R5 no valid in phase1", sum_valid_o, 0);
    opnd_c = W'(c);
    opnd_a = ~W'(a); opnd_b = ~W'(b); set_valid = ~v;
    @(negedge clk);
    prev_v   = v;
    prev_exp = a + b + c;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 phase in reset", phase_o, 0);
    chk("R1 valid in reset", sum_valid_o, 0);
    rst_n = 1'b1;
    chk("R1 phase after release", phase_o, 0);
    chk("R1 valid after release", sum_valid_o, 0);
    // R3 R8: exhaustive back-to-back sweep
    for (int i = 0; i < 512; i++) begin
      run_set(i % 8, (i / 8) % 8, i / 64, 1'b1);
    end
    // R6: alternating valid, including max operands
    for (int j = 0; j < 16; j++) begin
      run_set(7 - (j % 8), j % 8, 7, (j % 2) == 0);
    end
    run_set(0, 0, 0, 1'b0);
    chk("R6 final no valid", sum_valid_o, prev_v);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule